// File: doc/BRIEF.md
# Interlaced Vertical Scaler Phase Generator

This block produces the vertical interpolation phase for a line-based video scaler that must cope with interlaced sources. When a field begins, it forms a start phase for the luma path and for the chroma path. Each path has its own bank of four programmable offsets. The bank slot is chosen from the incoming field's parity and from a task bit that inverts on every field. A shared common offset is added to the chosen slot. A fixed half-line term is also added when the output field has the opposite parity to the input field and parity conversion is enabled.

After the field start, every output-line strobe adds a 16-bit scale increment to a fractional line accumulator. For each output line the block reports two values. The integer carry tells the line-memory controller how many input lines to advance. The top five fraction bits are the weight for a two-tap vertical filter.

Top module: `vsc_phase_gen`

## Requirements
- R1: After reset, `luma_adv`, `luma_wgt`, `chroma_adv`, `chroma_wgt`, `phase_vld` and `task_bit` are all zero.
- R2: On `fld_start`, the offset slot index is {`fld_id`, `task_bit`} (fld_id is the MSB). Slot n of a bank is bits [8n+7:8n] of `luma_ofs` or `chroma_ofs`.
- R3: `task_bit` inverts on the clock edge of every `fld_start`, and holds its value at every other edge.
- R4: One cycle after `fld_start`, each path reports start = slot + `com_ofs` + H, in 1/32-line units. Here H is 16 when `conv_en`=1 and `out_par` differs from `fld_id`, and 0 otherwise. The path's adv equals start/32 and its wgt equals start mod 32.
- R5: While `conv_en`=0, no half-line term is added, whatever the parities of the input and output fields.
- R6: One cycle after `line_step`, each path adds the scale increment to its 10-bit fraction, in 1/1024-line units. The fraction starts at (start mod 32)*32. adv is the carry out (sum/1024), and wgt is bits [9:5] of the new fraction. An increment of 1024 gives adv=1 and leaves wgt unchanged.
- R7: The scale increment used by line steps is captured at `fld_start`. Changes to `scale_inc` during a field have no effect until the next field start.
- R8: When `fld_start` and `line_step` are high in the same cycle, the field start takes precedence and the line step is ignored.
- R9: Luma and chroma start phases come from their own offset banks, and both paths use the same captured increment.
- R10: `phase_vld` is high exactly in the cycle after a `fld_start` or `line_step`. In all other cycles it is low, and all four phase outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fld_start | input | 1 | Field-start strobe |
| fld_id | input | 1 | Input field parity (1 = lower) |
| out_par | input | 1 | Output field parity (1 = lower) |
| conv_en | input | 1 | Enable half-line parity conversion |
| line_step | input | 1 | Output-line strobe |
| scale_inc | input | 16 | Vertical increment, 1024 = 1:1 |
| com_ofs | input | 8 | Common phase offset |
| luma_ofs | input | 32 | Four 8-bit luma offset slots |
| chroma_ofs | input | 32 | Four 8-bit chroma offset slots |
| luma_adv | output | 7 | Luma input-line advance |
| luma_wgt | output | 5 | Luma filter weight |
| chroma_adv | output | 7 | Chroma input-line advance |
| chroma_wgt | output | 5 | Chroma filter weight |
| phase_vld | output | 1 | Phase outputs updated this cycle |
| task_bit | output | 1 | Current task toggle state |

## Verification
A wrong task bit selects the wrong offset slot. The error shows in adv and wgt one cycle after the next field start, and it alternates from field to field. A corrupted fraction stays hidden for a while. It appears as a wrong weight one cycle after the next line step, and possibly as a carry that comes a line early or late. It is cleared only at the next field start. A captured increment that follows `scale_inc` during a field shows as a wrong advance on the first line step after the change.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  // fraction bits of the line accumulator (1/1024 line units)
  localparam int VSC_FRAC_W = 10;
  // weight bits exposed to the two-tap filter (1/32 line units)
  localparam int VSC_WGT_W  = 5;
  // number of components served (luma, chroma)
  localparam int VSC_NCOMP  = 2;

  typedef enum logic [0:0] {COMP_LUMA = 1'b0, COMP_CHROMA = 1'b1} vsc_comp_e;
endpackage

// File: rtl/vsc_sel.sv
module vsc_sel #(
  parameter int OFS_W   = 8,
  parameter int NSLOT   = 4,
  parameter int WGT_W   = 5,
  localparam int IDX_W  = $clog2(NSLOT),
  localparam int START_W = OFS_W + 2
) (
  input  logic [NSLOT*OFS_W-1:0] bank,
  input  logic [IDX_W-1:0]       idx,
  input  logic [OFS_W-1:0]       com,
  input  logic                   half,
  output logic [START_W-1:0]     start
);
  localparam int HALF_LINE = 1 << (WGT_W - 1);

  logic [OFS_W-1:0] slot [NSLOT];

  genvar s;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_slot
      assign slot[s] = bank[s*OFS_W +: OFS_W];
    end
  endgenerate

  function automatic logic [START_W-1:0] f_start(
    input logic [OFS_W-1:0] o, input logic [OFS_W-1:0] c, input logic h);
    logic [START_W-1:0] acc;
    acc = START_W'(o) + START_W'(c);
    if (h) acc = acc + START_W'(HALF_LINE);
    return acc;
  endfunction

  assign start = f_start(slot[idx], com, half);
endmodule

// File: rtl/vsc_acc.sv
module vsc_acc #(
  parameter int INC_W   = 16,
  parameter int FRAC_W  = 10,
  parameter int WGT_W   = 5,
  parameter int START_W = 10,
  localparam int ADV_W  = INC_W - FRAC_W + 1,
  localparam int SUM_W  = FRAC_W + ADV_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [START_W-1:0] start_val,
  input  logic [INC_W-1:0]   inc,
  output logic [ADV_W-1:0]   adv_o,
  output logic [WGT_W-1:0]   wgt_o
);
  localparam int SUB_W = FRAC_W - WGT_W;

  logic [FRAC_W-1:0] frac_q;

  // start phase in 1/32 units widened to 1/1024 units: {advance, fraction}
  function automatic logic [SUM_W-1:0] f_load(input logic [START_W-1:0] sv);
    return SUM_W'({sv, {SUB_W{1'b0}}});
  endfunction

  function automatic logic [SUM_W-1:0] f_step(
    input logic [FRAC_W-1:0] fr, input logic [INC_W-1:0] in);
    return SUM_W'(fr) + SUM_W'(in);
  endfunction

  logic [SUM_W-1:0] nxt;
  always_comb begin
    if (load) nxt = f_load(start_val);
    else      nxt = f_step(frac_q, inc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frac_q <= '0;
      adv_o  <= '0;
    end else if (load || step) begin
      frac_q <= nxt[FRAC_W-1:0];
      adv_o  <= nxt[SUM_W-1:FRAC_W];
    end
  end

  assign wgt_o = frac_q[FRAC_W-1 -: WGT_W];
endmodule

// File: rtl/vsc_phase_gen.sv
module vsc_phase_gen
  import vsc_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int INC_W = 16,
  parameter int NSLOT = 4,
  localparam int ADV_W = INC_W - VSC_FRAC_W + 1,
  localparam int START_W = OFS_W + 2,
  localparam int BANK_W = NSLOT * OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fld_start,
  input  logic               fld_id,
  input  logic               out_par,
  input  logic               conv_en,
  input  logic               line_step,
  input  logic [INC_W-1:0]   scale_inc,
  input  logic [OFS_W-1:0]   com_ofs,
  input  logic [BANK_W-1:0]  luma_ofs,
  input  logic [BANK_W-1:0]  chroma_ofs,
  output logic [ADV_W-1:0]   luma_adv,
  output logic [VSC_WGT_W-1:0] luma_wgt,
  output logic [ADV_W-1:0]   chroma_adv,
  output logic [VSC_WGT_W-1:0] chroma_wgt,
  output logic               phase_vld,
  output logic               task_bit
);
  // named internal events
  logic             line_evt;
  logic             half_req;
  logic [1:0]       sel_idx;
  logic [INC_W-1:0] shd_inc;

  assign line_evt = line_step & ~fld_start;
  assign half_req = conv_en & (out_par ^ fld_id);
  assign sel_idx  = {fld_id, task_bit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      task_bit  <= 1'b0;
      shd_inc   <= '0;
      phase_vld <= 1'b0;
    end else begin
      phase_vld <= fld_start | line_step;
      if (fld_start) begin
        task_bit <= ~task_bit;
        shd_inc  <= scale_inc;
      end
    end
  end

  logic [BANK_W-1:0]    bank_c  [VSC_NCOMP];
  logic [START_W-1:0]   start_c [VSC_NCOMP];
  logic [ADV_W-1:0]     adv_c   [VSC_NCOMP];
  logic [VSC_WGT_W-1:0] wgt_c   [VSC_NCOMP];

  assign bank_c[COMP_LUMA]   = luma_ofs;
  assign bank_c[COMP_CHROMA] = chroma_ofs;

  genvar c;
  generate
    for (c = 0; c < VSC_NCOMP; c++) begin : g_comp
      vsc_sel #(.OFS_W(OFS_W), .NSLOT(NSLOT), .WGT_W(VSC_WGT_W)) u_sel (
        .bank (bank_c[c]),
        .idx  (sel_idx),
        .com  (com_ofs),
        .half (half_req),
        .start(start_c[c])
      );
      vsc_acc #(.INC_W(INC_W), .FRAC_W(VSC_FRAC_W), .WGT_W(VSC_WGT_W),
                .START_W(START_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fld_start),
        .step     (line_evt),
        .start_val(start_c[c]),
        .inc      (shd_inc),
        .adv_o    (adv_c[c]),
        .wgt_o    (wgt_c[c])
      );
    end
  endgenerate

  assign luma_adv   = adv_c[COMP_LUMA];
  assign luma_wgt   = wgt_c[COMP_LUMA];
  assign chroma_adv = adv_c[COMP_CHROMA];
  assign chroma_wgt = wgt_c[COMP_CHROMA];
endmodule

// File: rtl/vsc_phase_gen_chk.sv
module vsc_phase_gen_chk #(
  parameter int INC_W = 16,
  parameter int ADV_W = 7,
  parameter int WGT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fld_start,
  input logic             line_step,
  input logic             line_evt,
  input logic             task_bit,
  input logic             phase_vld,
  input logic [ADV_W-1:0] luma_adv,
  input logic [WGT_W-1:0] luma_wgt,
  input logic [ADV_W-1:0] chroma_adv,
  input logic [WGT_W-1:0] chroma_wgt,
  input logic [INC_W-1:0] shd_inc
);
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    fld_start |=> (task_bit != $past(task_bit))); // R3
  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_start |=> $stable(task_bit)); // R3
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_start || line_step) |=> phase_vld); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(fld_start || line_step) |=> (!phase_vld && $stable(luma_adv) && $stable(luma_wgt)
                                   && $stable(chroma_adv) && $stable(chroma_wgt))); // R10
  AST_INC_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_start |=> $stable(shd_inc)); // R7
  AST_UNITY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_evt && shd_inc == INC_W'(1024)) |=>
      (luma_adv == ADV_W'(1) && luma_wgt == $past(luma_wgt))); // R6
  AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_start && line_step) |-> !line_evt); // R8
endmodule

bind vsc_phase_gen vsc_phase_gen_chk #(.INC_W(INC_W), .ADV_W(ADV_W), .WGT_W(vsc_pkg::VSC_WGT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fld_start(fld_start), .line_step(line_step),
  .line_evt(line_evt), .task_bit(task_bit), .phase_vld(phase_vld),
  .luma_adv(luma_adv), .luma_wgt(luma_wgt), .chroma_adv(chroma_adv),
  .chroma_wgt(chroma_wgt), .shd_inc(shd_inc)
);

// File: tb/vsc_phase_gen_tb.sv
module vsc_phase_gen_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic fld_start = 0, fld_id = 0, out_par = 0, conv_en = 0, line_step = 0;
  logic [15:0] scale_inc = 0;
  logic [7:0]  com_ofs = 0;
  logic [31:0] luma_ofs   = {8'h30, 8'h20, 8'h11, 8'h05};
  logic [31:0] chroma_ofs = {8'h0A, 8'h3F, 8'h00, 8'hFF};
  logic [6:0] luma_adv, chroma_adv;
  logic [4:0] luma_wgt, chroma_wgt;
  logic phase_vld, task_bit;

  always #2.5 clk = ~clk;

  vsc_phase_gen u_dut (
    .clk(clk), .rst_n(rst_n), .fld_start(fld_start), .fld_id(fld_id),
    .out_par(out_par), .conv_en(conv_en), .line_step(line_step),
    .scale_inc(scale_inc), .com_ofs(com_ofs), .luma_ofs(luma_ofs),
    .chroma_ofs(chroma_ofs), .luma_adv(luma_adv), .luma_wgt(luma_wgt),
    .chroma_adv(chroma_adv), .chroma_wgt(chroma_wgt),
    .phase_vld(phase_vld), .task_bit(task_bit)
  );

  int total = 0, bad = 0;
  int m_tog = 0, m_inc = 0;
  int m_frac[2];
  int m_adv[2];
  bit done = 0;

  // {fld_id, out_par, conv_en, com_ofs, inc}
  typedef struct packed {
    logic fid; logic opar; logic cen; logic [7:0] com; logic [15:0] inc;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b1, 8'd0,   16'd1024},
    '{1'b0, 1'b1, 1'b1, 8'd3,   16'd512},
    '{1'b1, 1'b1, 1'b1, 8'd0,   16'd2048},
    '{1'b1, 1'b0, 1'b1, 8'd10,  16'd1536},
    '{1'b0, 1'b1, 1'b0, 8'd0,   16'd1000},
    '{1'b1, 1'b0, 1'b0, 8'd255, 16'd65535},
    '{1'b0, 1'b0, 1'b1, 8'd200, 16'd33},
    '{1'b1, 1'b1, 1'b0, 8'd7,   16'd1024}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int slot_of(input logic [31:0] bank, input int idx);
    return int'((bank >> (idx * 8)) & 32'hFF);
  endfunction

  // drive a field start (optionally with a simultaneous line step) and check
  task automatic do_start(input logic fid, input logic opar, input logic cen,
                          input logic [7:0] com, input logic [15:0] inc,
                          input logic with_step, input string req);
    int idx, half, st;
    @(negedge clk);
    fld_start = 1; fld_id = fid; out_par = opar; conv_en = cen;
    com_ofs = com; scale_inc = inc; line_step = with_step;
    idx  = (int'(fid) << 1) | m_tog;
    half = (cen && (opar != fid)) ? 16 : 0;
    for (int c = 0; c < 2; c++) begin
      st = slot_of(c == 0 ? luma_ofs : chroma_ofs, idx) + int'(com) + half;
      m_adv[c]  = st / 32;
      m_frac[c] = (st % 32) * 32;
    end
    m_tog = 1 - m_tog;
    m_inc = int'(inc);
    @(negedge clk);
    fld_start = 0; line_step = 0;
    check({req, " luma adv"},   int'(luma_adv),   m_adv[0]);
    check({req, " luma wgt"},   int'(luma_wgt),   m_frac[0] / 32);
    check({req, " chroma adv"}, int'(chroma_adv), m_adv[1]);
    check({req, " chroma wgt"}, int'(chroma_wgt), m_frac[1] / 32);
    check("R3 task bit", int'(task_bit), m_tog);
    check("R10 vld after start", int'(phase_vld), 1);
  endtask

  task automatic do_step(input string req);
    int s;
    @(negedge clk);
    line_step = 1;
    for (int c = 0; c < 2; c++) begin
      s = m_frac[c] + m_inc;
      m_adv[c]  = s / 1024;
      m_frac[c] = s % 1024;
    end
    @(negedge clk);
    line_step = 0;
    check({req, " luma adv"},   int'(luma_adv),   m_adv[0]);
    check({req, " luma wgt"},   int'(luma_wgt),   m_frac[0] / 32);
    check({req, " chroma adv"}, int'(chroma_adv), m_adv[1]);
    check({req, " chroma wgt"}, int'(chroma_wgt), m_frac[1] / 32);
    check("R10 vld after step", int'(phase_vld), 1);
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 luma adv", int'(luma_adv), 0);
    check("R1 luma wgt", int'(luma_wgt), 0);
    check("R1 chroma adv", int'(chroma_adv), 0);
    check("R1 chroma wgt", int'(chroma_wgt), 0);
    check("R1 vld", int'(phase_vld), 0);
    check("R1 task bit", int'(task_bit), 0);
    rst_n = 1;

    // vector table: R2 slot selection, R4 half-line term, R5 no conversion, R6 steps, R9 banks
    for (int v = 0; v < 8; v++) begin
      do_start(VECS[v].fid, VECS[v].opar, VECS[v].cen, VECS[v].com, VECS[v].inc,
               1'b0, VECS[v].cen ? "R2 R4 R9 start" : "R2 R5 R9 start");
      for (int k = 0; k < 3; k++) do_step("R6 step");
    end

    // R7: increment change mid-field is not used
    do_start(1'b0, 1'b0, 1'b0, 8'd0, 16'd1024, 1'b0, "R7 start");
    @(negedge clk);
    scale_inc = 16'd300;
    do_step("R7 old increment");
    do_step("R7 old increment again");

    // R8: simultaneous start and step -> start only
    do_start(1'b1, 1'b0, 1'b1, 8'd1, 16'd700, 1'b1, "R8 start wins");
    do_step("R8 first step after");

    // R10: idle cycles hold outputs, vld low
    repeat (3) @(negedge clk);
    check("R10 idle vld", int'(phase_vld), 0);
    check("R10 idle luma adv", int'(luma_adv), m_adv[0]);
    check("R10 idle luma wgt", int'(luma_wgt), m_frac[0] / 32);
    check("R10 idle chroma wgt", int'(chroma_wgt), m_frac[1] / 32);
    check("R3 idle task bit", int'(task_bit), m_tog);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule